// File: doc/BRIEF.md
# Transmit Watermark FIFO with Cell-Available Flow Control

This block is the per-channel transmit buffer on a cell/packet egress port. An upstream master writes 32-bit words, each tagged with a start marker and, for packets, an end marker. The block holds them in a 64-word (256-byte) queue and hands them to a downstream consumer through a valid/ready read port. It also drives a registered transmit-available flag that tells the master whether it may keep sending.

The flag has two modes. In packet mode it compares the fill level with a programmable high watermark given in words. In ATM mode it looks at whole 13-word cells. While the channel is idle, the flag allows a new cell only if the free space can hold a complete cell. Eight words into a cell, the block projects the fill level to the end of that cell. If the following cell would not fit, the flag drops. With back-to-back writes, this drop comes four cycles before the last word of the current cell. The cell in progress is still taken in full.

Words are withheld from the reader until the fill level reaches a programmable release count, or until a complete cell or a packet end has been written, whichever happens first. A write into a full queue is discarded and sets a sticky error flag.

Top module: `wmfifo_tx`

## Requirements
- R1: Accepted words leave in write order. While `rd_valid` is high, `rd_data`, `rd_sop` and `rd_eop` show the oldest stored word. The queue holds 64 words.
- R2: In packet mode (`mode_atm`=0), `tx_avail` is low when the fill level in words is nonzero and at or above the sampled watermark `hwm_words` (range 0..64).
- R3: `tx_avail` is high in the cycle after any cycle in which the queue is empty, in both modes.
- R4: `tx_avail` is a register. In packet mode it shows the fill level of the previous cycle, so a watermark crossing in either direction appears one clock after the level changes.
- R5: In ATM mode (`mode_atm`=1), with no cell in progress, `tx_avail` is high only if the level plus 13 words does not exceed 64.
- R6: In ATM mode, once 8 words of the current cell are stored, `tx_avail` becomes (level + words still due in the cell + 13 ≤ 64). Before that point in a cell, the flag holds its value. With back-to-back writes, the flag falls at the edge that takes cell word 9 when the next cell cannot fit.
- R7: In ATM mode, a low `tx_avail` does not stop the cell in progress. All of its remaining words are stored while space exists.
- R8: A write while 64 words are stored is discarded and sets `ovf_err`. `ovf_err` stays high until reset.
- R9: `rd_valid` rises one clock after the level reaches the sampled `rel_words`. It rises at once, at the writing edge, when a packet end or the 13th word of a cell is stored. It stays high until the queue drains to empty.
- R10: `mode_atm`, `hwm_words` and `rel_words` are sampled only in cycles with no cell or packet in progress. Changes made mid-frame take effect after the frame ends.
- R11: After reset the queue is empty, `tx_avail`=1, `rd_valid`=0 and `ovf_err`=0.
- R12: In ATM mode, a cell is 13 words counted from the word with `wr_sop`=1. Its 13th word is read back with `rd_eop`=1, and `wr_eop` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Master presents a word |
| wr_data | input | 32 | Write word |
| wr_sop | input | 1 | Word starts a cell or packet |
| wr_eop | input | 1 | Word ends a packet (packet mode only) |
| mode_atm | input | 1 | 1 = ATM cell mode, 0 = packet mode |
| hwm_words | input | 7 | High watermark in 4-byte words |
| rel_words | input | 7 | Release threshold in words |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_valid | output | 1 | Head word is released to the consumer |
| rd_data | output | 32 | Head word data |
| rd_sop | output | 1 | Head word starts a frame |
| rd_eop | output | 1 | Head word ends a frame |
| tx_avail | output | 1 | Master may keep sending |
| ovf_err | output | 1 | Sticky write-overflow error |

## Verification
The bound checker checks the following on every cycle:
- the flag is forced high after an empty cycle;
- the packet-mode watermark comparison holds in both directions, one clock later;
- overflow is flagged and stays set;
- the read side never offers a word from an empty queue;
- the watermark stays frozen inside a frame.

The ATM look-ahead needs directed scenarios, because it depends on the word position inside a cell:
- the exact edge at which the flag falls;
- that the flag holds earlier in the cell;
- that the trailing words are still accepted.

Scenarios also cover the release point, the end-of-cell tag, write order and the discarding of words on overflow.

// File: rtl/wmfifo_pkg.sv
package wmfifo_pkg;
    typedef enum logic {
        MODE_PKT = 1'b0,
        MODE_ATM = 1'b1
    } tx_mode_e;

    // sideband bits stored beside each data word: {sop, eop}
    localparam int TAG_W = 2;
endpackage

// File: rtl/wmfifo_store.sv
module wmfifo_store #(
    parameter int WORD_W = 34,
    parameter int DEPTH  = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_next
);
    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [LVL_W-1:0] level;
    } store_st_t;

    store_st_t s_d, s_q;
    logic [WORD_W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wptr = bump(s_q.wptr);
        if (pop)  s_d.rptr = bump(s_q.rptr);
        case ({push, pop})
            2'b10:   s_d.level = s_q.level + 1'b1;
            2'b01:   s_d.level = s_q.level - 1'b1;
            default: s_d.level = s_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[s_q.wptr] <= push_word;
    end

    assign head_word  = mem[s_q.rptr];
    assign level      = s_q.level;
    assign level_next = s_d.level;
endmodule

// File: rtl/wmfifo_frame.sv
module wmfifo_frame
    import wmfifo_pkg::*;
#(
    parameter int CELL_WORDS = 13,
    parameter int LVL_W      = 7,
    localparam int CW_W      = $clog2(CELL_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic             mode_atm,
    input  logic [LVL_W-1:0] hwm_in,
    input  logic [LVL_W-1:0] rel_in,
    output tx_mode_e         cfg_mode,
    output logic [LVL_W-1:0] cfg_hwm,
    output logic [LVL_W-1:0] cfg_rel,
    output logic [CW_W-1:0]  cell_cnt,
    output logic             in_frame,
    output logic             frame_last
);
    typedef struct packed {
        tx_mode_e         mode;
        logic [LVL_W-1:0] hwm;
        logic [LVL_W-1:0] rel;
        logic [CW_W-1:0]  cw;
        logic             busy;
    } frame_st_t;

    frame_st_t s_d, s_q;
    logic [CW_W-1:0] cw_nx;

    always_comb begin
        s_d        = s_q;
        frame_last = 1'b0;
        cw_nx      = s_q.cw;
        // configuration only follows the inputs between frames
        if (!s_q.busy) begin
            s_d.mode = tx_mode_e'(mode_atm);
            s_d.hwm  = hwm_in;
            s_d.rel  = rel_in;
        end
        if (accept) begin
            if (s_q.mode == MODE_ATM) begin
                if (wr_sop)             cw_nx = CW_W'(1);
                else if (s_q.cw != '0)  cw_nx = s_q.cw + 1'b1;
                else                    cw_nx = '0;
                if (cw_nx == CW_W'(CELL_WORDS)) begin
                    frame_last = 1'b1;
                    cw_nx      = '0;
                end
                s_d.cw   = cw_nx;
                s_d.busy = (cw_nx != '0);
            end else begin
                s_d.cw = '0;
                if (wr_eop) begin
                    frame_last = 1'b1;
                    s_d.busy   = 1'b0;
                end else if (wr_sop) begin
                    s_d.busy = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_PKT, default: '0};
        else        s_q <= s_d;
    end

    assign cfg_mode = s_q.mode;
    assign cfg_hwm  = s_q.hwm;
    assign cfg_rel  = s_q.rel;
    assign cell_cnt = s_q.cw;
    assign in_frame = s_q.busy;
endmodule

// File: rtl/wmfifo_avail.sv
module wmfifo_avail
    import wmfifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int CELL_WORDS = 13,
    parameter int LOOKAHEAD  = 4,
    parameter int LVL_W      = 7,
    parameter int CW_W       = 4,
    localparam int SUM_W     = LVL_W + 2,
    localparam int LOOK_AT   = (CELL_WORDS > LOOKAHEAD) ? CELL_WORDS - LOOKAHEAD - 1 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tx_mode_e         cfg_mode,
    input  logic [LVL_W-1:0] cfg_hwm,
    input  logic [LVL_W-1:0] level,
    input  logic [CW_W-1:0]  cell_cnt,
    output logic             avail
);
    logic             avail_d, avail_q;
    logic [SUM_W-1:0] lvl_w, rem_w;

    always_comb begin
        lvl_w   = SUM_W'(level);
        rem_w   = SUM_W'(CELL_WORDS) - SUM_W'(cell_cnt);
        avail_d = avail_q;
        if (level == '0) begin
            avail_d = 1'b1;
        end else if (cfg_mode == MODE_PKT) begin
            avail_d = (level < cfg_hwm);
        end else if (cell_cnt == '0) begin
            avail_d = (lvl_w + SUM_W'(CELL_WORDS) <= SUM_W'(DEPTH));
        end else if (cell_cnt >= CW_W'(LOOK_AT)) begin
            // project the level to the end of the current cell
            avail_d = (lvl_w + rem_w + SUM_W'(CELL_WORDS) <= SUM_W'(DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) avail_q <= 1'b1;
        else        avail_q <= avail_d;
    end

    assign avail = avail_q;
endmodule

// File: rtl/wmfifo_release.sv
module wmfifo_release #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_next,
    input  logic [LVL_W-1:0] cfg_rel,
    input  logic             push,
    input  logic             frame_last,
    output logic             gate_open
);
    logic open_d, open_q;

    always_comb begin
        open_d = open_q
              || ((level != '0) && (level >= cfg_rel))
              || (push && frame_last);
        if (level_next == '0) open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end

    assign gate_open = open_q;
endmodule

// File: rtl/wmfifo_tx.sv
module wmfifo_tx
    import wmfifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 64,
    parameter int CELL_WORDS = 13,
    parameter int LOOKAHEAD  = 4,
    localparam int LVL_W     = $clog2(DEPTH + 1),
    localparam int CW_W      = $clog2(CELL_WORDS + 1),
    localparam int WORD_W    = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              mode_atm,
    input  logic [LVL_W-1:0]  hwm_words,
    input  logic [LVL_W-1:0]  rel_words,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              tx_avail,
    output logic              ovf_err
);
    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t          s_d, s_q;
    logic             accept, pop, gate_open, frame_last, in_frame;
    logic [LVL_W-1:0] level, level_next, cfg_hwm, cfg_rel;
    logic [CW_W-1:0]  cell_cnt;
    tx_mode_e         cfg_mode;
    logic [WORD_W-1:0] head_word;

    assign accept   = wr_valid && (level != LVL_W'(DEPTH));
    assign rd_valid = gate_open && (level != '0);
    assign pop      = rd_valid && rd_ready;

    wmfifo_frame #(.CELL_WORDS(CELL_WORDS), .LVL_W(LVL_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .mode_atm(mode_atm),
        .hwm_in(hwm_words), .rel_in(rel_words),
        .cfg_mode(cfg_mode), .cfg_hwm(cfg_hwm), .cfg_rel(cfg_rel),
        .cell_cnt(cell_cnt), .in_frame(in_frame), .frame_last(frame_last)
    );

    wmfifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(accept),
        .push_word({wr_sop, frame_last, wr_data}),
        .pop(pop), .head_word(head_word),
        .level(level), .level_next(level_next)
    );

    wmfifo_avail #(
        .DEPTH(DEPTH), .CELL_WORDS(CELL_WORDS), .LOOKAHEAD(LOOKAHEAD),
        .LVL_W(LVL_W), .CW_W(CW_W)
    ) u_avail (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_hwm(cfg_hwm),
        .level(level), .cell_cnt(cell_cnt), .avail(tx_avail)
    );

    wmfifo_release #(.LVL_W(LVL_W)) u_release (
        .clk(clk), .rst_n(rst_n), .level(level), .level_next(level_next),
        .cfg_rel(cfg_rel), .push(accept), .frame_last(frame_last),
        .gate_open(gate_open)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ovf = s_q.ovf || (wr_valid && (level == LVL_W'(DEPTH)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ovf_err = s_q.ovf;
    assign rd_sop  = head_word[DATA_W+1];
    assign rd_eop  = head_word[DATA_W];
    assign rd_data = head_word[DATA_W-1:0];
endmodule

// File: rtl/wmfifo_tx_chk.sv
module wmfifo_tx_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] cfg_hwm,
    input logic             cfg_atm,
    input logic             in_frame,
    input logic             wr_valid,
    input logic             rd_valid,
    input logic             tx_avail,
    input logic             ovf_err
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_pkt_at_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_atm && level != '0 && level >= cfg_hwm) |=> !tx_avail);

    assert_empty_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> tx_avail);

    assert_pkt_below_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_atm && level < cfg_hwm) |=> tx_avail);

    assert_ovf_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && level == LVL_W'(DEPTH)) |=> ovf_err);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    assert_rd_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (level != '0));

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |=> $stable(cfg_hwm));
endmodule

bind wmfifo_tx wmfifo_tx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .level(level), .cfg_hwm(cfg_hwm),
    .cfg_atm(cfg_mode == wmfifo_pkg::MODE_ATM), .in_frame(in_frame),
    .wr_valid(wr_valid), .rd_valid(rd_valid), .tx_avail(tx_avail),
    .ovf_err(ovf_err)
);

// File: tb/test_wmfifo_tx.sv
`timescale 1ns/1ps
module test_wmfifo_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mode_atm = 1'b0, rd_ready = 1'b0;
    logic [6:0]  hwm_words = '0, rel_words = '0;
    logic        rd_valid, rd_sop, rd_eop, tx_avail, ovf_err;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    wmfifo_tx i_wmfifo_tx (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_sop(wr_sop), .wr_eop(wr_eop), .mode_atm(mode_atm),
        .hwm_words(hwm_words), .rel_words(rel_words), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop),
        .rd_eop(rd_eop), .tx_avail(tx_avail), .ovf_err(ovf_err)
    );

    // {atm, hwm[7:0], words[7:0], expected flag}
    localparam int NVEC = 14;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 8'd16, 8'd15, 1'b1},   // R2 below mark
        {1'b0, 8'd16, 8'd16, 1'b0},   // R2 at mark
        {1'b0, 8'd16, 8'd20, 1'b0},   // R2 above mark
        {1'b0, 8'd0,  8'd0,  1'b1},   // R3 empty
        {1'b0, 8'd0,  8'd1,  1'b0},   // R2 zero mark
        {1'b0, 8'd64, 8'd63, 1'b1},   // R2
        {1'b0, 8'd64, 8'd64, 1'b0},   // R2 full
        {1'b1, 8'd0,  8'd39, 1'b1},   // R5 three cells
        {1'b1, 8'd0,  8'd52, 1'b0},   // R5 four cells
        {1'b1, 8'd0,  8'd0,  1'b1},   // R3 empty atm
        {1'b1, 8'd0,  8'd46, 1'b1},   // R6 hold before look-ahead
        {1'b1, 8'd0,  8'd47, 1'b0},   // R6 look-ahead drop
        {1'b1, 8'd0,  8'd35, 1'b1},   // R6 next cell fits
        {1'b1, 8'd0,  8'd13, 1'b1}    // R5 one cell
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [31:0] d, input logic s, input logic e);
        wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic fill(input int n, input logic atm, input int base);
        for (int i = 0; i < n; i++)
            put(32'(base + i), atm ? (i % 13 == 0) : (i == 0), 1'b0);
    endtask

    task automatic drain(input int base, output int cnt, output int bad, output logic last_eop);
        cnt = 0; bad = 0; last_eop = 1'b0;
        rd_ready = 1'b1;
        while (rd_valid) begin
            if (rd_data !== 32'(base + cnt)) bad++;
            last_eop = rd_eop;
            cnt++;
            @(negedge clk);
        end
        rd_ready = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cnt, bad;
        logic leop;

        // R11 reset state
        hwm_words = 7'd16; rel_words = 7'd64;
        do_reset();
        chk("R11 avail", {31'd0, tx_avail}, 32'd1);
        chk("R11 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R11 ovf", {31'd0, ovf_err}, 32'd0);

        // vector table: fill, then one idle edge, then check the flag
        for (int v = 0; v < NVEC; v++) begin
            mode_atm  = VEC[v][17];
            hwm_words = VEC[v][15:9];
            rel_words = 7'd64;
            do_reset();
            fill(int'(VEC[v][8:1]), VEC[v][17], 0);
            @(negedge clk);
            chk($sformatf("R2/R3/R5/R6 vec%0d", v), {31'd0, tx_avail}, {31'd0, VEC[v][0]});
        end

        // R6/R7: flag falls at edge of cell word 9, rest of cell accepted
        mode_atm = 1'b1; rel_words = 7'd64;
        do_reset();
        fill(39, 1'b1, 32'h100);
        for (int k = 0; k < 13; k++) begin
            put(32'(32'h100 + 39 + k), k == 0, 1'b0);
            if (k == 7) chk("R6 before look-ahead", {31'd0, tx_avail}, 32'd1);
            if (k == 8) chk("R6 drop four before end", {31'd0, tx_avail}, 32'd0);
        end
        drain(32'h100, cnt, bad, leop);
        chk("R7 whole cell accepted", 32'(cnt), 32'd52);
        chk("R7 data order", 32'(bad), 32'd0);
        chk("R12 last word tagged", {31'd0, leop}, 32'd1);
        chk("R7 no overflow", {31'd0, ovf_err}, 32'd0);

        // R9/R12: ATM release only at the 13th word
        do_reset();
        fill(12, 1'b1, 32'h200);
        @(negedge clk);
        chk("R9 cell incomplete held", {31'd0, rd_valid}, 32'd0);
        put(32'h20C, 1'b0, 1'b1);
        chk("R9 cell end releases", {31'd0, rd_valid}, 32'd1);
        chk("R12 head sop", {31'd0, rd_sop}, 32'd1);
        drain(32'h200, cnt, bad, leop);
        chk("R12 cell length", 32'(cnt), 32'd13);
        chk("R12 eop on 13th", {31'd0, leop}, 32'd1);

        // R9: release on count threshold
        mode_atm = 1'b0; hwm_words = 7'd64; rel_words = 7'd8;
        do_reset();
        fill(7, 1'b0, 32'h300);
        @(negedge clk);
        chk("R9 below release", {31'd0, rd_valid}, 32'd0);
        put(32'h307, 1'b0, 1'b0);
        chk("R9 release one clock later a", {31'd0, rd_valid}, 32'd0);
        @(negedge clk);
        chk("R9 release one clock later b", {31'd0, rd_valid}, 32'd1);
        drain(32'h300, cnt, bad, leop);
        chk("R1 drain count", 32'(cnt), 32'd8);
        chk("R1 order", 32'(bad), 32'd0);

        // R9: packet end releases early
        do_reset();
        put(32'h400, 1'b1, 1'b0);
        put(32'h401, 1'b0, 1'b0);
        put(32'h402, 1'b0, 1'b1);
        chk("R9 eop releases", {31'd0, rd_valid}, 32'd1);
        chk("R1 head data", rd_data, 32'h400);
        drain(32'h400, cnt, bad, leop);
        chk("R1 eop tag", {31'd0, leop}, 32'd1);

        // R4: read lowers level, flag follows one clock later
        hwm_words = 7'd16; rel_words = 7'd0;
        do_reset();
        fill(16, 1'b0, 0);
        @(negedge clk);
        chk("R2 at mark", {31'd0, tx_avail}, 32'd0);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        chk("R4 flag lags a", {31'd0, tx_avail}, 32'd0);
        @(negedge clk);
        chk("R4 flag lags b", {31'd0, tx_avail}, 32'd1);

        // R10: watermark frozen inside a packet
        hwm_words = 7'd16; rel_words = 7'd64;
        do_reset();
        put(32'h500, 1'b1, 1'b0);
        hwm_words = 7'd2;
        fill(4, 1'b1, 32'h501);
        @(negedge clk);
        chk("R10 old mark mid frame", {31'd0, tx_avail}, 32'd1);
        put(32'h505, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10 sample after end", {31'd0, tx_avail}, 32'd1);
        @(negedge clk);
        chk("R10 new mark applied", {31'd0, tx_avail}, 32'd0);

        // R8: overflow drops word and sticks
        hwm_words = 7'd64; rel_words = 7'd64;
        do_reset();
        fill(65, 1'b0, 32'h1000);
        chk("R8 ovf set", {31'd0, ovf_err}, 32'd1);
        @(negedge clk);
        drain(32'h1000, cnt, bad, leop);
        chk("R8 extra word dropped", 32'(cnt), 32'd64);
        chk("R8 data intact", 32'(bad), 32'd0);
        chk("R8 ovf sticky", {31'd0, ovf_err}, 32'd1);
        @(negedge clk);
        chk("R3 empty after drain", {31'd0, tx_avail}, 32'd1);
        do_reset();
        chk("R11 ovf cleared", {31'd0, ovf_err}, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule